// File: doc/BRIEF.md
# Serial Byte Transmitter with Bus Collision Monitor

This block sends bytes as asynchronous serial frames on a single-wire, open-drain style bus, where the transmitter's own output also shows up on its receive pin. Software writes a byte into a one-entry holding buffer. The byte then moves into a shifter and goes out with 16 oversample ticks per bit. The ticks come in as a one-cycle enable strobe. Baud generation is outside this block.

While a frame is on the wire, a monitor reads the bus back. The read-back passes through a two-stage synchronizer. At one selectable tick inside each bit, the monitor compares the bit it read back with the bit it sent. A difference means another node is driving the bus.

When the monitor sees a difference, it does four things:
- It ends the frame and returns the line to idle.
- It throws away any byte waiting in the holding buffer.
- It raises a sticky error flag, which can also drive an interrupt.
- It blocks new frames until software clears the flag by writing one.

Top module: `serial_tx_bitmon`

## Requirements
- R1: A frame is one start bit (logic 0), then eight data bits with the LSB first, then one stop bit (logic 1). Each bit lasts 16 `os_tick` strobes. The idle line is logic 1. The pin is `txd` = logic level XOR `tx_inv`.
- R2: A write on `wr_en` is accepted only while `tdre`=1. `tdre`=1 means the holding buffer is empty. A write while `tdre`=0 is ignored. `tc`=1 when no frame is in progress and the buffer is empty.
- R3: `chk_mode` 2'b01 compares at the 9th tick of each bit, and 2'b10 compares at the 13th tick. Codes 2'b00 and 2'b11 perform no compare. With those codes, a corrupted read-back never sets `berr`.
- R4: Compares happen only while a frame is in progress. Bus activity while the transmitter is idle does not set `berr`.
- R5: `rxd` goes through a two-flop synchronizer. The received logic level is the synchronized pin XOR `rx_inv`.
- R6: After a mismatch, `txd` shows the idle level (high when `tx_inv`=0, low when `tx_inv`=1) from the next clock cycle on.
- R7: A mismatch ends the frame and discards the byte in the holding buffer. Afterwards `tdre`=1 and `tc`=1.
- R8: A mismatch sets `berr`. `irq` is 1 exactly when `berr` and `berr_ie` are both 1.
- R9: No frame starts while `berr`=1. A byte written during lockout stays buffered. It is sent once a `berr_clr` pulse (write-one-to-clear) removes the flag.
- R10: While `chk_mode` selects no compare, `berr` is held at 0. A flag that was already set clears in the next cycle.
- R11: Unequal `tx_inv` and `rx_inv` settings on a looped-back bus produce a bit error, even when no other node is driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample strobe, 16 per bit |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| tdre | output | 1 | Holding buffer empty |
| tc | output | 1 | Transmitter idle and buffer empty |
| chk_mode | input | 2 | Collision compare mode |
| tx_inv | input | 1 | Invert transmit pin |
| rx_inv | input | 1 | Invert receive pin |
| txd | output | 1 | Transmit pin |
| rxd | input | 1 | Receive pin (bus read-back) |
| berr_clr | input | 1 | Write-one-to-clear for the bit error flag |
| berr_ie | input | 1 | Bit error interrupt enable |
| berr | output | 1 | Bit error flag |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following:
- The flag never rises while idle and is held low while compares are off.
- The pin returns to idle when the flag rises.
- Both empty flags are up at that moment.
- An abort drops the frame and the buffer.
- A set flag keeps an idle transmitter idle.

Only the bench scenarios can show the rest:
- The bit order and bit length of each frame.
- Which tick is the sample point. A disturbance is placed between tick 9 and tick 13 of a bit.
- That the discarded byte never reappears.
- That a lockout byte goes out after the clear.

// File: rtl/serial_tx_bitmon_pkg.sv
package serial_tx_bitmon_pkg;
  typedef enum logic [1:0] {
    CHK_OFF   = 2'b00,
    CHK_EARLY = 2'b01,
    CHK_LATE  = 2'b10,
    CHK_RSVD  = 2'b11
  } chk_mode_e;
endpackage

// File: rtl/stb_rx_sync.sv
module stb_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb pipe_n = d_in;
    end else begin : g_many
      always_comb pipe_n = {pipe_q[STAGES-2:0], d_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_n;
  end

  assign q_out = pipe_q[STAGES-1];
endmodule

// File: rtl/stb_frame_tx.sv
module stb_frame_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int CNT_W  = $clog2(OSR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hold,
  input  logic              abort,
  output logic              line_bit,
  output logic              active,
  output logic [CNT_W-1:0]  tick_pos,
  output logic              buf_empty
);
  localparam int NB    = DATA_W + 2;
  localparam int IDX_W = $clog2(NB);

  logic [DATA_W-1:0] buf_q, buf_n;
  logic              full_q, full_n;
  logic [NB-1:0]     sh_q, sh_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [CNT_W-1:0]  tick_q, tick_n;
  logic              act_q, act_n;
  logic              start;

  assign start = !act_q && full_q && !hold;

  always_comb begin
    buf_n  = buf_q;
    full_n = full_q;
    sh_n   = sh_q;
    idx_n  = idx_q;
    tick_n = tick_q;
    act_n  = act_q;
    if (abort) begin
      act_n  = 1'b0;
      full_n = 1'b0;
    end else begin
      if (start) begin
        sh_n   = {1'b1, buf_q, 1'b0};
        act_n  = 1'b1;
        idx_n  = '0;
        tick_n = '0;
        full_n = 1'b0;
      end else if (act_q && os_tick) begin
        if (tick_q == CNT_W'(OSR - 1)) begin
          tick_n = '0;
          sh_n   = {1'b1, sh_q[NB-1:1]};
          if (idx_q == IDX_W'(NB - 1)) act_n = 1'b0;
          else                         idx_n = idx_q + 1'b1;
        end else begin
          tick_n = tick_q + 1'b1;
        end
      end
      if (wr_en && !full_q) begin
        buf_n  = wr_data;
        full_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      tick_q <= '0;
      act_q  <= 1'b0;
    end else begin
      buf_q  <= buf_n;
      full_q <= full_n;
      sh_q   <= sh_n;
      idx_q  <= idx_n;
      tick_q <= tick_n;
      act_q  <= act_n;
    end
  end

  assign line_bit  = act_q ? sh_q[0] : 1'b1;
  assign active    = act_q;
  assign tick_pos  = tick_q;
  assign buf_empty = !full_q;

  // R9: a raised error flag keeps an idle transmitter idle
  a_r9_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !act_q) |=> !act_q);
  // R7: an abort from the monitor drops both the frame and the buffer
  a_r7_abort_drops: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!act_q && !full_q));
endmodule

// File: rtl/stb_bit_mon.sv
module stb_bit_mon
  import serial_tx_bitmon_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int SAMP_EARLY = 9,
  parameter int SAMP_LATE  = 13,
  parameter int CNT_W      = $clog2(OSR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic [1:0]       mode,
  input  logic             active,
  input  logic [CNT_W-1:0] tick_pos,
  input  logic             tx_bit,
  input  logic             rx_bit,
  input  logic             clr,
  output logic             abort,
  output logic             flag
);
  logic             check_en;
  logic [CNT_W-1:0] samp_pos;
  logic             flag_q, flag_n;

  assign check_en = (mode == CHK_EARLY) || (mode == CHK_LATE);
  assign samp_pos = (mode == CHK_LATE) ? CNT_W'(SAMP_LATE - 1) : CNT_W'(SAMP_EARLY - 1);
  assign abort    = check_en && active && os_tick && (tick_pos == samp_pos) && (tx_bit != rx_bit);

  always_comb begin
    flag_n = flag_q;
    if (!check_en)  flag_n = 1'b0;
    else if (abort) flag_n = 1'b1;
    else if (clr)   flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_n;
  end

  assign flag = flag_q;

  // R10: with compares off the flag is low one cycle later
  a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !check_en |=> !flag_q);
  // R4: an idle transmitter never raises the flag
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !$rose(flag_q));
endmodule

// File: rtl/serial_tx_bitmon.sv
module serial_tx_bitmon
  import serial_tx_bitmon_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SAMP_EARLY  = 9,
  parameter int SAMP_LATE   = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tdre,
  output logic              tc,
  input  logic [1:0]        chk_mode,
  input  logic              tx_inv,
  input  logic              rx_inv,
  output logic              txd,
  input  logic              rxd,
  input  logic              berr_clr,
  input  logic              berr_ie,
  output logic              berr,
  output logic              irq
);
  localparam int CNT_W = $clog2(OSR);

  logic             rx_s, line_bit, active, buf_empty, abort, flag;
  logic [CNT_W-1:0] tick_pos;

  stb_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rxd), .q_out(rx_s)
  );

  stb_frame_tx #(.DATA_W(DATA_W), .OSR(OSR), .CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .wr_en(wr_en), .wr_data(wr_data),
    .hold(flag), .abort(abort), .line_bit(line_bit), .active(active),
    .tick_pos(tick_pos), .buf_empty(buf_empty)
  );

  stb_bit_mon #(.OSR(OSR), .SAMP_EARLY(SAMP_EARLY), .SAMP_LATE(SAMP_LATE), .CNT_W(CNT_W)) u_mon (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .mode(chk_mode), .active(active),
    .tick_pos(tick_pos), .tx_bit(line_bit), .rx_bit(rx_s ^ rx_inv), .clr(berr_clr),
    .abort(abort), .flag(flag)
  );

  assign txd  = line_bit ^ tx_inv;
  assign tdre = buf_empty;
  assign tc   = buf_empty && !active;
  assign berr = flag;
  assign irq  = flag && berr_ie;

  // R6: pin shows the idle level once the error flag rises
  a_r6_idle_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (txd == !tx_inv));
  // R7: both empty indications are up when the error flag rises
  a_r7_flags_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (tdre && tc));
endmodule

// File: tb/sim_serial_tx_bitmon.sv
module sim_serial_tx_bitmon;
  logic clk = 1'b0;
  logic rst_n, os_tick, wr_en, tx_inv, rx_inv, berr_clr, berr_ie;
  logic [7:0] wr_data;
  logic [1:0] chk_mode;
  logic tdre, tc, txd, berr, irq, rxd;
  logic force_en, force_val;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  assign rxd = force_en ? force_val : txd;

  serial_tx_bitmon u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .wr_en(wr_en), .wr_data(wr_data),
    .tdre(tdre), .tc(tc), .chk_mode(chk_mode), .tx_inv(tx_inv), .rx_inv(rx_inv),
    .txd(txd), .rxd(rxd), .berr_clr(berr_clr), .berr_ie(berr_ie), .berr(berr), .irq(irq)
  );

  // data, mode, tx_inv, rx_inv
  localparam logic [11:0] VEC [5] = '{
    {8'h55, 2'b01, 1'b0, 1'b0},
    {8'hA3, 2'b10, 1'b0, 1'b0},
    {8'h00, 2'b10, 1'b1, 1'b1},
    {8'hFF, 2'b01, 1'b1, 1'b1},
    {8'h3C, 2'b00, 1'b0, 1'b0}
  };

  initial begin
    os_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk); berr_clr = 1'b1;
    @(negedge clk); berr_clr = 1'b0;
  endtask

  task automatic wait_start(output bit seen);
    seen = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ((txd ^ tx_inv) == 1'b0) begin seen = 1; break; end
    end
  endtask

  task automatic capture(output logic [9:0] bits);
    bit seen;
    bits = '0;
    wait_start(seen);
    if (!seen) begin bits = 10'h3FF; return; end
    repeat (32) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      bits[k] = txd ^ tx_inv;
      if (k < 9) repeat (64) @(negedge clk);
    end
  endtask

  task automatic idle_watch(input int n, output int moved);
    moved = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ((txd ^ tx_inv) !== 1'b1) moved++;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [9:0] got;
    int moved;
    bit seen;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; chk_mode = 2'b01;
    tx_inv = 1'b0; rx_inv = 1'b0; berr_clr = 1'b0; berr_ie = 1'b1;
    force_en = 1'b0; force_val = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R1 idle level, R2 flags, R8)
    check("R1 reset txd", txd, 1);
    check("R2 reset tdre", tdre, 1);
    check("R2 reset tc", tc, 1);
    check("R8 reset berr", berr, 0);

    // vector table: clean loopback frames, R1 R3 R5
    foreach (VEC[i]) begin
      chk_mode = VEC[i][3:2]; tx_inv = VEC[i][1]; rx_inv = VEC[i][0];
      repeat (4) @(negedge clk);
      write_byte(VEC[i][11:4]);
      capture(got);
      check("R1 frame bits", got, {1'b1, VEC[i][11:4], 1'b0});
      repeat (80) @(negedge clk);
      check("R5 no error on clean loopback", berr, 0);
      check("R2 tc after frame", tc, 1);
    end
    tx_inv = 1'b0; rx_inv = 1'b0;

    // R2: third write while buffer full is ignored
    chk_mode = 2'b01;
    write_byte(8'h12);
    write_byte(8'h34);
    check("R2 tdre low with buffered byte", tdre, 0);
    write_byte(8'h56);
    capture(got);
    check("R2 first frame", got, {1'b1, 8'h12, 1'b0});
    capture(got);
    check("R2 second frame", got, {1'b1, 8'h34, 1'b0});
    repeat (100) @(negedge clk);
    check("R2 ignored write never sent", tc, 1);
    idle_watch(300, moved);
    check("R2 line idle after two frames", moved, 0);

    // R3: disturbance between tick 9 and tick 13 of bit 1
    for (int m = 0; m < 2; m++) begin
      chk_mode = (m == 0) ? 2'b01 : 2'b10;
      write_byte(8'hFF);
      wait_start(seen);
      repeat (108) @(negedge clk);
      force_val = 1'b0; force_en = 1'b1;
      repeat (16) @(negedge clk);
      force_en = 1'b0;
      repeat (700) @(negedge clk);
      check(m == 0 ? "R3 tick9 mode misses late disturbance" : "R3 tick13 mode sees disturbance",
            berr, m);
      clear_err();
    end

    // R3: compare-off codes ignore a corrupted bus
    foreach (VEC[i]) begin
      if (i > 1) break;
      chk_mode = (i == 0) ? 2'b00 : 2'b11;
      force_val = 1'b0; force_en = 1'b1;
      write_byte(8'hFF);
      repeat (750) @(negedge clk);
      force_en = 1'b0;
      check("R3 off code no error", berr, 0);
      check("R3 off code frame completes", tc, 1);
    end

    // R4: bus noise while idle
    chk_mode = 2'b01;
    force_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); force_val = i[2];
    end
    force_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 idle noise no error", berr, 0);

    // collision: R6 R7 R8
    berr_ie = 1'b1;
    write_byte(8'hFF);
    wait_start(seen);
    write_byte(8'h81);
    check("R7 second byte buffered", tdre, 0);
    repeat (68) @(negedge clk);
    force_val = 1'b0; force_en = 1'b1;
    repeat (60) @(negedge clk);
    force_en = 1'b0;
    check("R8 berr set", berr, 1);
    check("R8 irq with enable", irq, 1);
    check("R7 tdre after abort", tdre, 1);
    check("R7 tc after abort", tc, 1);
    check("R6 txd idle after abort", txd, 1);
    berr_ie = 1'b0;
    @(negedge clk);
    check("R8 irq masked", irq, 0);
    idle_watch(800, moved);
    check("R6 line stays idle", moved, 0);

    // R9: lockout with a buffered byte, then clear releases it
    write_byte(8'h33);
    idle_watch(800, moved);
    check("R9 no frame during lockout", moved, 0);
    check("R9 byte held", tdre, 0);
    clear_err();
    capture(got);
    check("R9 released byte, R7 discarded byte absent", got, {1'b1, 8'h33, 1'b0});
    repeat (100) @(negedge clk);
    check("R7 nothing after released byte", tc, 1);

    // R11: polarity mismatch gives false error
    tx_inv = 1'b1; rx_inv = 1'b0;
    repeat (4) @(negedge clk);
    write_byte(8'h00);
    repeat (200) @(negedge clk);
    check("R11 mismatched polarity flags error", berr, 1);
    check("R6 idle level with inverted pin", txd, 0);

    // R10: switching compare off clears the flag
    chk_mode = 2'b00;
    @(negedge clk);
    check("R10 flag cleared when off", berr, 0);
    tx_inv = 1'b0;
    repeat (4) @(negedge clk);

    finish_run();
  end
endmodule